// File: doc/BRIEF.md
# Two-Level Page Translation Walker

This block turns a 32-bit linear address into a physical address by reading two levels of translation tables from memory. The top ten bits of the linear address select an entry in a page directory. The next ten bits select an entry in the page table that the directory entry points to. The low twelve bits pass through unchanged as the offset within the page. The physical base of the directory comes from a directory base input. Every table entry is a 4-byte word. The upper 20 bits of an entry hold a page frame number, and bit 0 of an entry is a present flag.

A client offers one linear address on a valid/ready request port. The walker fetches the two entries through a single read port. That port holds its request until the memory acknowledges it with data. The walker then pulses a one-cycle response that carries either the physical address or a fault. When the paging enable input is low at acceptance, the walker skips translation: it answers with the linear address itself and reads nothing from memory. Only one translation is in flight at any time.

Top module: `page_walker`

## Requirements
- R1: If `pg_en_i` is low when a request is accepted, the response in the next cycle has `rsp_addr_o` equal to the linear address and `rsp_fault_o` low, and `mem_req_o` stays low for the whole transaction.
- R2: The first read of a walk uses address {`dir_base_i`[31:12], lin[31:22], 2'b00}. The low 12 bits of the base input are ignored.
- R3: The second read uses address {pde[31:12], lin[21:12], 2'b00}, where pde is the directory entry. Bits 11:1 of the directory entry have no effect on this address.
- R4: A successful walk responds with {pte[31:12], lin[11:0]}, where pte is the page-table entry, and `rsp_fault_o` low. Bits 11:1 of the page-table entry do not appear in the result.
- R5: If the directory entry has bit 0 clear, the walk ends with `rsp_fault_o` high and `rsp_addr_o` equal to the linear address, and no second read is made.
- R6: If the page-table entry has bit 0 clear, the walk ends with `rsp_fault_o` high and `rsp_addr_o` equal to the linear address.
- R7: `req_ready_o` is low from the cycle after acceptance up to and including the response cycle, and is high again in the cycle after the response.
- R8: The walker samples `dir_base_i` and `pg_en_i` only at acceptance. Changes to them during a walk do not alter its reads or its result.
- R9: While `mem_req_o` is high and `mem_ack_i` is low, `mem_req_o` and `mem_addr_o` hold in the next cycle. The walker takes the read data in the cycle in which `mem_ack_i` is high.
- R10: After reset, `req_ready_o` is high, and `rsp_valid_o` and `mem_req_o` are low.
- R11: `rsp_valid_o` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A translation request is offered |
| req_ready_o | output | 1 | The walker is idle and accepts a request |
| req_lin_i | input | 32 | Linear address to translate |
| dir_base_i | input | 32 | Physical base of the page directory; bits 31:12 are used |
| pg_en_i | input | 1 | Paging enable; when low, translation is bypassed |
| mem_req_o | output | 1 | Table-entry read request, held until acknowledged |
| mem_addr_o | output | 32 | Byte address of the entry being read |
| mem_ack_i | input | 1 | Read acknowledge; `mem_rdata_i` is valid in this cycle |
| mem_rdata_i | input | 32 | Entry word returned by memory |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_fault_o | output | 1 | Response is a page fault |
| rsp_addr_o | output | 32 | Physical address, or the faulting linear address |

## Verification
The bench fills the low 12 bits of every entry and of the base with non-zero patterns. A walker that forgets to mask them would form wrong entry addresses or put attribute bits into the physical address. It clears the present bit first in the directory entry and then in the page-table entry. A design that kept walking would make a stray second read or return a frame instead of the linear address. After each acceptance it changes the base and the enable inputs to other values. A walker that reads them live would read from the wrong directory or take the wrong path. It varies the memory latency, so a request that drops or moves its address before the acknowledge shows up as a changed address or an extra read.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned OFF_W   = 12;
  localparam int unsigned IDX_W   = 10;
  localparam int unsigned ENT_LOG = 2;
  localparam int unsigned FRAME_W = ADDR_W - OFF_W;
  localparam int unsigned PRES_BIT = 0;

  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_DIR  = 2'd1,
    W_TBL  = 2'd2,
    W_RESP = 2'd3
  } walk_st_e;

  function automatic logic [ADDR_W-1:0] entry_addr(
    input logic [FRAME_W-1:0] frame,
    input logic [IDX_W-1:0]   idx
  );
    return {frame, idx, {ENT_LOG{1'b0}}};
  endfunction
endpackage

// File: rtl/pw_req_latch.sv
module pw_req_latch
  import pw_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [ADDR_W-1:0]  lin_i,
  input  logic [ADDR_W-1:0]  base_i,
  output logic [ADDR_W-1:0]  lin_o,
  output logic [FRAME_W-1:0] base_frame_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lin_o        <= '0;
      base_frame_o <= '0;
    end else if (load_i) begin
      lin_o        <= lin_i;
      base_frame_o <= base_i[ADDR_W-1 -: FRAME_W];
    end
  end
endmodule

// File: rtl/pw_addr_gen.sv
module pw_addr_gen
  import pw_pkg::*;
(
  input  walk_st_e           state_i,
  input  logic [ADDR_W-1:0]  lin_i,
  input  logic [FRAME_W-1:0] base_frame_i,
  input  logic [FRAME_W-1:0] pde_frame_i,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam int unsigned DIR_LSB = OFF_W + IDX_W;

  logic [IDX_W-1:0] dir_idx, tbl_idx;
  assign dir_idx = lin_i[DIR_LSB +: IDX_W];
  assign tbl_idx = lin_i[OFF_W +: IDX_W];

  always_comb begin
    addr_o = '0;
    unique case (state_i)
      W_DIR:   addr_o = entry_addr(base_frame_i, dir_idx);
      W_TBL:   addr_o = entry_addr(pde_frame_i, tbl_idx);
      default: addr_o = '0;
    endcase
  end
endmodule

// File: rtl/pw_fsm.sv
module pw_fsm
  import pw_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [ADDR_W-1:0]  req_lin_i,
  input  logic               pg_en_i,
  input  logic [ADDR_W-1:0]  lin_q_i,
  input  logic               mem_ack_i,
  input  logic [ADDR_W-1:0]  mem_rdata_i,
  output walk_st_e           state_o,
  output logic               accept_o,
  output logic [FRAME_W-1:0] pde_frame_o,
  output logic               rsp_fault_o,
  output logic [ADDR_W-1:0]  rsp_addr_o
);
  walk_st_e state_d;
  logic     present;

  assign accept_o = (state_o == W_IDLE) && req_valid_i;
  assign present  = mem_rdata_i[PRES_BIT];

  always_comb begin
    state_d = state_o;
    unique case (state_o)
      W_IDLE: if (req_valid_i) state_d = pg_en_i ? W_DIR : W_RESP;
      W_DIR:  if (mem_ack_i)   state_d = present ? W_TBL : W_RESP;
      W_TBL:  if (mem_ack_i)   state_d = W_RESP;
      W_RESP:                  state_d = W_IDLE;
      default:                 state_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o     <= W_IDLE;
      pde_frame_o <= '0;
      rsp_fault_o <= 1'b0;
      rsp_addr_o  <= '0;
    end else begin
      state_o <= state_d;
      unique case (state_o)
        W_IDLE: if (req_valid_i && !pg_en_i) begin
          rsp_fault_o <= 1'b0;
          rsp_addr_o  <= req_lin_i;
        end
        W_DIR: if (mem_ack_i) begin
          pde_frame_o <= mem_rdata_i[ADDR_W-1 -: FRAME_W];
          if (!present) begin
            rsp_fault_o <= 1'b1;
            rsp_addr_o  <= lin_q_i;
          end
        end
        W_TBL: if (mem_ack_i) begin
          rsp_fault_o <= !present;
          rsp_addr_o  <= present ? {mem_rdata_i[ADDR_W-1 -: FRAME_W], lin_q_i[OFF_W-1:0]}
                                 : lin_q_i;
        end
        default: ;
      endcase
    end
  end

  // R1: bypass answers next cycle without touching memory
  a_r1_bypass_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && !pg_en_i) |=> (state_o == W_RESP));
  // R5: absent directory entry never reaches table level
  a_r5_no_tbl_after_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == W_DIR && mem_ack_i && !present) |=> (state_o == W_RESP && rsp_fault_o));
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [31:0] req_lin_i,
  input  logic [31:0] dir_base_i,
  input  logic        pg_en_i,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_ack_i,
  input  logic [31:0] mem_rdata_i,
  output logic        rsp_valid_o,
  output logic        rsp_fault_o,
  output logic [31:0] rsp_addr_o
);
  walk_st_e           state;
  logic               accept;
  logic [ADDR_W-1:0]  lin_q;
  logic [FRAME_W-1:0] base_frame_q, pde_frame_q;

  pw_req_latch i_latch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (accept),
    .lin_i        (req_lin_i),
    .base_i       (dir_base_i),
    .lin_o        (lin_q),
    .base_frame_o (base_frame_q)
  );

  pw_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_lin_i   (req_lin_i),
    .pg_en_i     (pg_en_i),
    .lin_q_i     (lin_q),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .state_o     (state),
    .accept_o    (accept),
    .pde_frame_o (pde_frame_q),
    .rsp_fault_o (rsp_fault_o),
    .rsp_addr_o  (rsp_addr_o)
  );

  pw_addr_gen i_addr (
    .state_i      (state),
    .lin_i        (lin_q),
    .base_frame_i (base_frame_q),
    .pde_frame_i  (pde_frame_q),
    .addr_o       (mem_addr_o)
  );

  assign req_ready_o = (state == W_IDLE);
  assign mem_req_o   = (state == W_DIR) || (state == W_TBL);
  assign rsp_valid_o = (state == W_RESP);

  a_r9_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
  a_r7_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o));
  a_r7_no_ready_on_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);
endmodule

// File: tb/test_page_walker.sv
module test_page_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_lin = '0;
  logic [31:0] dir_base = '0;
  logic        pg_en = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_addr;

  int vectors = 0;
  int errors  = 0;
  int lat     = 0;
  int wait_cnt = 0;
  int rd_cnt  = 0;
  bit flt_dir = 0, flt_tbl = 0;
  logic [31:0] rd_addr [4];
  logic        prev_pend = 1'b0;
  logic [31:0] prev_addr = '0;

  always #10 clk = ~clk;

  page_walker i_page_walker (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_lin_i(req_lin),
    .dir_base_i(dir_base), .pg_en_i(pg_en),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_addr_o(rsp_addr)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a, input bit pres);
    logic [31:0] h;
    h = (a ^ (a >> 7)) * 32'h9E37_79B1;
    return {h[31:12], 11'b101_1001_1010, pres};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model: acknowledges after lat idle cycles, logs read addresses
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
      prev_pend <= 1'b0;
    end else if (mem_req) begin
      if (prev_pend) check("R9 address held", mem_addr, prev_addr);
      if (wait_cnt >= lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem_word(mem_addr, rd_cnt == 0 ? !flt_dir : !flt_tbl);
        if (rd_cnt < 4) rd_addr[rd_cnt] <= mem_addr;
        rd_cnt   <= rd_cnt + 1;
        wait_cnt <= 0;
        prev_pend <= 1'b0;
      end else begin
        wait_cnt  <= wait_cnt + 1;
        prev_pend <= 1'b1;
        prev_addr <= mem_addr;
      end
    end
  end

  task automatic xlate(input logic [31:0] lin, input logic [31:0] base, input bit en,
                       input int l, input bit fd, input bit ft, input string tag);
    logic [31:0] pde_a, pde, pte_a, pte, exp_addr;
    int exp_rd, cyc;
    bit exp_flt;
    pde_a = {base[31:12], lin[31:22], 2'b00};
    pde   = mem_word(pde_a, !fd);
    pte_a = {pde[31:12], lin[21:12], 2'b00};
    pte   = mem_word(pte_a, !ft);
    if (!en) begin exp_rd = 0; exp_flt = 0; exp_addr = lin; end
    else if (fd) begin exp_rd = 1; exp_flt = 1; exp_addr = lin; end
    else if (ft) begin exp_rd = 2; exp_flt = 1; exp_addr = lin; end
    else begin exp_rd = 2; exp_flt = 0; exp_addr = {pte[31:12], lin[11:0]}; end

    @(negedge clk);
    lat = l; flt_dir = fd; flt_tbl = ft; rd_cnt = 0;
    check({"R7 ready idle ", tag}, {31'd0, req_ready}, 32'd1);
    req_lin = lin; dir_base = base; pg_en = en; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    // R8: disturb sampled inputs during the walk
    dir_base = ~base; pg_en = ~en; req_lin = ~lin;
    cyc = 0;
    while (!rsp_valid && cyc < 200) begin
      if (req_ready) check({"R7 busy ", tag}, {31'd0, req_ready}, 32'd0);
      if (!en && mem_req) check({"R1 no read ", tag}, {31'd0, mem_req}, 32'd0);
      cyc++;
      @(negedge clk);
    end
    check({"R11 response seen ", tag}, {31'd0, rsp_valid}, 32'd1);
    check({"R7 not ready in rsp ", tag}, {31'd0, req_ready}, 32'd0);
    if (!en) check({"R1 one-cycle bypass ", tag}, cyc, 0);
    check({"R1/R5 read count ", tag}, rd_cnt, exp_rd);
    if (exp_rd > 0) check({"R2 dir entry addr ", tag}, rd_addr[0], pde_a);
    if (exp_rd > 1) check({"R3 tbl entry addr ", tag}, rd_addr[1], pte_a);
    check({"R5/R6 fault ", tag}, {31'd0, rsp_fault}, {31'd0, exp_flt});
    check({"R4/R8 rsp addr ", tag}, rsp_addr, exp_addr);
    @(negedge clk);
    check({"R11 pulse ends ", tag}, {31'd0, rsp_valid}, 32'd0);
    check({"R7 ready again ", tag}, {31'd0, req_ready}, 32'd1);
    check({"R9 mem idle ", tag}, {31'd0, mem_req}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 ready in reset", {31'd0, req_ready}, 32'd1);
    check("R10 rsp in reset", {31'd0, rsp_valid}, 32'd0);
    check("R10 mem in reset", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ready after reset", {31'd0, req_ready}, 32'd1);

    xlate(32'h1234_5678, 32'h0010_0000, 1'b0, 0, 0, 0, "R1 bypass");
    xlate(32'h0000_0000, 32'h0010_0000, 1'b0, 0, 0, 0, "R1 zero");
    xlate(32'h8040_1ABC, 32'h0020_0000, 1'b1, 0, 0, 0, "R4 lat0");
    xlate(32'hFFFF_FFFF, 32'h0030_0FFF, 1'b1, 3, 0, 0, "R2 base low bits");
    xlate(32'h0000_0000, 32'hFFFF_F000, 1'b1, 1, 0, 0, "R3 low corner");
    xlate(32'h7FC0_0123, 32'h0040_0000, 1'b1, 2, 1, 0, "R5 dir fault");
    xlate(32'h0040_3456, 32'h0040_0000, 1'b1, 4, 0, 1, "R6 tbl fault");
    xlate(32'hC0DE_BEEF, 32'hABCD_E123, 1'b1, 5, 0, 0, "R8 long walk");
    xlate(32'h0000_1001, 32'h0050_0000, 1'b0, 0, 0, 0, "R8 en sampled");
    for (int k = 0; k < 8; k++)
      xlate(32'h1357_9BDF * (k + 1), 32'h0011_1000 * (k + 3), 1'b1, k % 4,
            (k == 5), (k == 6), "R4 sweep");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule